// File: doc/BRIEF.md
# Peripheral Soft-Reset Register Block

This block is a small bus-attached register set that owns a bank of active-low reset lines, one line per peripheral in a cluster. Software puts peripherals into reset by writing a mask to a hold register and takes them out again by writing a mask to a release register. Only the lines whose mask bits are 1 change. A level register reads back what each line is actually driving.

The block decodes a 4 KiB window, and each cluster gets its own instance. To cycle a peripheral through reset, software writes its bit to the hold register and then to the release register. Each line moves on the clock after the write, so any software wait between the two writes sets the reset width. Read data is registered and appears one clock after the read strobe.

Top module: `prst_softreset_regs`

## Requirements
- R1: While reset is active and directly after it, every reset line is low (all peripherals in reset) and read data is 0.
- R2: A write to offset 0x01C drives low every line whose write-data bit is 1. The change is visible on the clock after the write, and lines whose bit is 0 keep their level.
- R3: A write to offset 0x018 drives high every line whose write-data bit is 1. The change is visible on the clock after the write, and lines whose bit is 0 keep their level.
- R4: A read of offset 0x020 returns the line levels, bit i being line i (0 = in reset). The value is valid on the clock after the read strobe.
- R5: Reads of offsets 0x018 and 0x01C return 0.
- R6: Reads of any other offset in the window return 0, and writes to such offsets leave every line unchanged.
- R7: A write of an all-zero mask to 0x018 or 0x01C changes no line.
- R8: A write to 0x01C followed on the very next clock by a write to 0x018 with the same mask holds those lines low for exactly one clock.
- R9: In a cycle with no read strobe, the read data register returns to 0 on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_addr | input | 12 | Byte offset within the 4 KiB window |
| bus_wdata | input | N (32) | Write data, one bit per line |
| bus_wr | input | 1 | Write strobe, one clock per transfer |
| bus_rd | input | 1 | Read strobe, one clock per transfer |
| bus_rdata | output | N (32) | Registered read data |
| periph_rst_n | output | N (32) | Active-low reset lines to the peripherals |

## Verification
The hardest case to reach is the one-clock reset pulse. It needs a hold write and a release write on consecutive clocks, and the line must be sampled in the single cycle between them. The bench drives the two writes on back-to-back negative edges and samples after each of them. It also rewrites a mask that partly overlaps the current state, which shows that bits written as 0 keep their level.

// File: rtl/prst_pkg.sv
package prst_pkg;
    localparam int unsigned ADDR_W = 12;

    // Offsets are fixed by the software interface
    localparam logic [ADDR_W-1:0] OFS_RELEASE = 12'h018;
    localparam logic [ADDR_W-1:0] OFS_HOLD    = 12'h01C;
    localparam logic [ADDR_W-1:0] OFS_LEVEL   = 12'h020;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RELEASE,
        SEL_HOLD,
        SEL_LEVEL
    } reg_sel_e;
endpackage

// File: rtl/prst_decode.sv
module prst_decode
    import prst_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        case (addr)
            OFS_RELEASE: sel = SEL_RELEASE;
            OFS_HOLD:    sel = SEL_HOLD;
            OFS_LEVEL:   sel = SEL_LEVEL;
            default:     sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/prst_lines.sv
module prst_lines #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_mask,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] level
);
    typedef struct packed {
        logic [N-1:0] level;
    } line_st_t;

    line_st_t st_d, st_q;

    // Clear has priority so a bit requested both ways stays in reset
    always_comb begin
        st_d       = st_q;
        st_d.level = (st_q.level | set_mask) & ~clr_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
endmodule

// File: rtl/prst_rdport.sv
module prst_rdport
    import prst_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  reg_sel_e     sel,
    input  logic [N-1:0] level,
    output logic [N-1:0] rdata
);
    typedef struct packed {
        logic [N-1:0] data;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d.data = '0;
        if (rd && sel == SEL_LEVEL) st_d.data = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.data;
endmodule

// File: rtl/prst_softreset_regs.sv
module prst_softreset_regs
    import prst_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [N-1:0]      bus_rdata,
    output logic [N-1:0]      periph_rst_n
);
    reg_sel_e     sel;
    logic [N-1:0] set_mask;
    logic [N-1:0] clr_mask;

    prst_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (bus_wr && sel == SEL_RELEASE) set_mask = bus_wdata;
        if (bus_wr && sel == SEL_HOLD)    clr_mask = bus_wdata;
    end

    prst_lines #(.N(N)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .level    (periph_rst_n)
    );

    prst_rdport #(.N(N)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .sel   (sel),
        .level (periph_rst_n),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/prst_softreset_chk.sv
module prst_softreset_chk
    import prst_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [N-1:0]      bus_rdata,
    input logic [N-1:0]      periph_rst_n
);
    logic wr_rel, wr_hold;
    assign wr_rel  = bus_wr && bus_addr == OFS_RELEASE;
    assign wr_hold = bus_wr && bus_addr == OFS_HOLD;

    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (periph_rst_n == '0 && bus_rdata == '0));

    assert_hold_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hold |=> ((periph_rst_n & $past(bus_wdata)) == '0));

    assert_release_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rel && !wr_hold) |=> ((periph_rst_n & $past(bus_wdata)) == $past(bus_wdata)));

    assert_level_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_LEVEL) |=> (bus_rdata == $past(periph_rst_n)));

    assert_other_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != OFS_LEVEL) |=> (bus_rdata == '0));

    assert_no_write_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_rel || wr_hold) |=> $stable(periph_rst_n));

    assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));
endmodule

bind prst_softreset_regs prst_softreset_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_rdata    (bus_rdata),
    .periph_rst_n (periph_rst_n)
);

// File: tb/prst_softreset_regs_tb.sv
module prst_softreset_regs_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  periph_rst_n;

    int total = 0;
    int bad = 0;
    logic [N-1:0] exp_lines = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prst_softreset_regs #(.N(N)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_rdata    (bus_rdata),
        .periph_rst_n (periph_rst_n)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-clock write; on return the edge has applied it
    task automatic bus_write(input logic [11:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // One-clock read; on return bus_rdata holds the registered result
    task automatic bus_read(input logic [11:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [N-1:0] r;
        check("R1 lines in reset", periph_rst_n, '0);
        check("R1 rdata in reset", bus_rdata, '0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 lines after reset", periph_rst_n, '0);
        bus_read(12'h020, r);
        check("R1 level read after reset", r, '0);
    endtask

    task automatic t_release();
        bus_write(12'h018, 32'h0000_00FF);
        exp_lines |= 32'h0000_00FF;
        check("R3 release low byte", periph_rst_n, exp_lines);
        bus_write(12'h018, 32'hA500_0F00);
        exp_lines |= 32'hA500_0F00;
        check("R3 release more, others kept", periph_rst_n, exp_lines);
    endtask

    task automatic t_hold();
        bus_write(12'h01C, 32'h0000_0F0F);
        exp_lines &= ~32'h0000_0F0F;
        check("R2 hold overlapping mask", periph_rst_n, exp_lines);
        bus_write(12'h01C, 32'h8000_0000);
        exp_lines &= ~32'h8000_0000;
        check("R2 hold top bit", periph_rst_n, exp_lines);
    endtask

    task automatic t_status();
        logic [N-1:0] r;
        bus_read(12'h020, r);
        check("R4 level read", r, exp_lines);
        bus_write(12'h018, 32'hFFFF_FFFF);
        exp_lines = '1;
        bus_read(12'h020, r);
        check("R4 level read all released", r, '1);
    endtask

    task automatic t_write_only();
        logic [N-1:0] r;
        bus_read(12'h018, r);
        check("R5 release offset reads 0", r, '0);
        bus_read(12'h01C, r);
        check("R5 hold offset reads 0", r, '0);
    endtask

    task automatic t_undefined();
        logic [N-1:0] r;
        bus_write(12'h000, 32'hFFFF_FFFF);
        check("R6 write 0x000 ignored", periph_rst_n, exp_lines);
        bus_write(12'h01D, 32'hFFFF_FFFF);
        check("R6 write 0x01D ignored", periph_rst_n, exp_lines);
        bus_write(12'hFFC, 32'h1234_5678);
        check("R6 write 0xFFC ignored", periph_rst_n, exp_lines);
        bus_read(12'h024, r);
        check("R6 read 0x024 is 0", r, '0);
        bus_read(12'hFFC, r);
        check("R6 read 0xFFC is 0", r, '0);
    endtask

    task automatic t_zero_mask();
        bus_write(12'h01C, 32'h0);
        check("R7 zero hold mask", periph_rst_n, exp_lines);
        bus_write(12'h01C, 32'h0000_F000);
        exp_lines &= ~32'h0000_F000;
        bus_write(12'h018, 32'h0);
        check("R7 zero release mask", periph_rst_n, exp_lines);
    endtask

    task automatic t_pulse();
        @(negedge clk);
        bus_addr = 12'h01C; bus_wdata = 32'h0000_0030; bus_wr = 1'b1;
        @(negedge clk);
        check("R8 pulse low after hold", periph_rst_n, exp_lines & ~32'h0000_0030);
        bus_addr = 12'h018;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        exp_lines |= 32'h0000_0030;
        check("R8 pulse high after release", periph_rst_n, exp_lines);
    endtask

    task automatic t_idle_rdata();
        @(negedge clk);
        bus_addr = 12'h020; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R4 level read before idle", bus_rdata, exp_lines);
        @(negedge clk);
        check("R9 rdata cleared without strobe", bus_rdata, '0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2 + 1);
        t_reset();
        t_release();
        t_hold();
        t_status();
        t_write_only();
        t_undefined();
        t_zero_mask();
        t_pulse();
        t_idle_rdata();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule